// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master

This block is a register-mapped serial peripheral master that moves one 8-bit byte in each direction per start command. A processor reaches it through a byte-wide bus of eight offsets. It picks the clock polarity, the sampling phase, the bit order, the enable and an internal loopback path in a mode register. It loads a byte to send, then writes a start strobe. The block drives the serial clock and the outgoing data line and samples the incoming line. When the eighth bit is in, it sets a received-byte flag and raises a level interrupt. Software reads the byte back and starts the next one.

The serial clock is derived from a quarter-rate view of the bus clock. With divider value N, each serial clock phase lasts 2*(N+1) bus cycles, so the serial rate is (bus/4)/(N+1). Chip selects are driven elsewhere and are not part of this block.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0, status reads 0, SCLK and MOSI are low and IRQ is low.
- R2: Offset 0 holds a 5-bit mode field (bit 4 early-sample phase, bit 3 enable, bit 2 LSB-first, bit 1 clock idles high, bit 0 loopback) and reads 0 in bits 7..5. Offset 2 holds the transmit byte and offset 6 holds the divider; both read back as written. Offsets 3, 5 and 7 read 0.
- R3: Writing offset 3 with bit 0 set, while enable is 1 and no transfer runs, sets the busy flag (status bit 1) from the next cycle. The block then makes exactly 16 SCLK edges that carry 8 bits.
- R4: With bit 4 set (modes 0 and 2), the first data bit is on MOSI before the first edge and data is sampled on leading edges. With bit 4 clear (modes 1 and 3), data changes on leading edges and is sampled on trailing edges. Bit 1 sets the SCLK idle level high.
- R5: With bit 2 clear, bit 7 moves first in both directions. With bit 2 set, bit 0 moves first.
- R6: When a byte completes, busy clears and the received-byte flag (status bit 0) sets on the same cycle. The received byte then reads at offset 1.
- R7: IRQ is high while the received-byte flag is set and enable is 1. A read of offset 1 clears the flag, and IRQ drops the cycle after.
- R8: A start strobe written while busy is ignored. The running byte keeps its data and its length.
- R9: While enable is 0, SCLK stays at its idle level, MOSI is low and start strobes are ignored. Clearing enable during a transfer stops it, and no received-byte flag is set.
- R10: With bit 0 (loopback) set, the received byte equals the transmitted byte, whatever MISO does.
- R11: From the clock edge that registers the start strobe to the edge that sets the received-byte flag takes 32*(N+1) bus cycles, where N is the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, byte ready |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The properties assume a bus that raises at most one of the read and write strobes at a time, holds each strobe for a single cycle and keeps the address valid with it. They also assume the mode register is not rewritten during a transfer, except to clear the enable. The bench drives every access through one task pair that meets these rules. It changes polarity, phase and order only between transfers. The only mid-transfer writes it makes are a new transmit byte, a second start strobe and clearing the enable. A bench slave model shifts MISO on the edges the selected mode defines, and it changes MISO half a bus cycle after each SCLK edge, well away from the edge where the block samples.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 3'd6;

    localparam int MODE_W = 5;
    localparam int GO_BIT = 0;

    // Field order sets the bit positions: early=4 .. loop=0
    typedef struct packed {
        logic early;   // sample on leading edge
        logic en;      // port enable
        logic lsb;     // LSB first
        logic cidle;   // clock idles high
        logic loop;    // internal loopback
    } mode_t;

endpackage

// File: rtl/spi_byte_clkgen.sv
module spi_byte_clkgen #(
    parameter int DIV_W    = 8,
    parameter int RATE_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int HALF_MUL = RATE_DIV / 2;
    localparam int CNT_W    = DIV_W + $clog2(RATE_DIV);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_m1;

    assign half_m1 = CNT_W'(HALF_MUL) * (CNT_W'(div) + CNT_W'(1)) - CNT_W'(1);
    assign tick    = run && (cnt_q == half_m1);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              early,
    input  logic              lsb,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_in,
    output logic              busy,
    output logic              phase,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic              mosi;
        logic [EDGE_W-1:0] edges;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_t;

    sh_t s_d, s_q;

    logic [DATA_W-1:0] tx_rev;
    logic [DATA_W-1:0] tx_sel;
    logic [EDGE_W-1:0] e_nx;
    logic [IDX_W-1:0]  pos;
    logic [IDX_W-1:0]  rpos;
    logic              leading;
    logic              first_bit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign tx_rev[i] = s_q.tx[DATA_W-1-i];
    end

    assign tx_sel    = lsb ? s_q.tx : tx_rev;
    assign e_nx      = s_q.edges + EDGE_W'(1);
    assign pos       = IDX_W'((e_nx - EDGE_W'(1)) >> 1);
    assign rpos      = lsb ? pos : (IDX_W'(DATA_W - 1) - pos);
    assign leading   = e_nx[0];
    assign first_bit = lsb ? tx_byte[0] : tx_byte[DATA_W-1];

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (abort) begin
            s_d.busy  = 1'b0;
            s_d.phase = 1'b0;
            s_d.mosi  = 1'b0;
            s_d.edges = '0;
        end else if (start && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.phase = 1'b0;
            s_d.edges = '0;
            s_d.tx    = tx_byte;
            s_d.mosi  = first_bit;
        end else if (s_q.busy && tick) begin
            s_d.edges = e_nx;
            s_d.phase = ~s_q.phase;
            if (leading == early) begin
                s_d.rx[rpos] = rx_in;
            end
            if (!early && leading) begin
                s_d.mosi = tx_sel[pos];
            end
            if (early && !leading && (e_nx != EDGE_W'(EDGES))) begin
                s_d.mosi = tx_sel[pos + IDX_W'(1)];
            end
            if (e_nx == EDGE_W'(EDGES)) begin
                s_d.busy  = 1'b0;
                s_d.edges = '0;
                done      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign phase   = s_q.phase;
    assign mosi    = s_q.mosi;
    assign rx_byte = s_q.rx;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int RATE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    typedef struct packed {
        mode_t             mode;
        logic [DATA_W-1:0] txd;
        logic [DIV_W-1:0]  div;
        logic              rbr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              sh_busy;
    logic              sh_phase;
    logic              sh_mosi;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rx;
    logic              tick;
    logic              start;
    logic              abort;
    logic              rx_in;
    logic              en_q;
    logic              cidle_q;

    assign en_q    = regs_q.mode.en;
    assign cidle_q = regs_q.mode.cidle;

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_MODE: regs_d.mode = mode_t'(bus_wdata[MODE_W-1:0]);
                OFF_TXD:  regs_d.txd  = bus_wdata;
                OFF_DIV:  regs_d.div  = bus_wdata[DIV_W-1:0];
                OFF_CTRL: start = bus_wdata[GO_BIT] && regs_q.mode.en && !sh_busy;
                default:  ;
            endcase
        end
        if (bus_rd && (bus_addr == OFF_RXD)) begin
            regs_d.rbr = 1'b0;
        end
        if (sh_done) begin
            regs_d.rbr = 1'b1;
        end
    end

    assign abort = !regs_d.mode.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MODE: bus_rdata = DATA_W'(regs_q.mode);
            OFF_RXD:  bus_rdata = sh_rx;
            OFF_TXD:  bus_rdata = regs_q.txd;
            OFF_STAT: bus_rdata = DATA_W'({sh_busy, regs_q.rbr});
            OFF_DIV:  bus_rdata = DATA_W'(regs_q.div);
            default:  bus_rdata = '0;
        endcase
    end

    assign rx_in = regs_q.mode.loop ? sh_mosi : miso;

    spi_byte_clkgen #(
        .DIV_W    (DIV_W),
        .RATE_DIV (RATE_DIV)
    ) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sh_busy),
        .div  (regs_q.div),
        .tick (tick)
    );

    spi_byte_shifter #(
        .DATA_W(DATA_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (abort),
        .tick   (tick),
        .early  (regs_q.mode.early),
        .lsb    (regs_q.mode.lsb),
        .tx_byte(regs_q.txd),
        .rx_in  (rx_in),
        .busy   (sh_busy),
        .phase  (sh_phase),
        .mosi   (sh_mosi),
        .done   (sh_done),
        .rx_byte(sh_rx)
    );

    assign sclk = cidle_q ^ sh_phase;
    assign mosi = sh_mosi;
    assign irq  = regs_q.rbr && en_q;

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       go_bit,
    input logic       en,
    input logic       cidle,
    input logic       sclk,
    input logic       mosi,
    input logic       irq,
    input logic       bsy,
    input logic       rbr,
    input logic       done
);
    logic go_wr;
    logic rx_rd;
    assign go_wr = bus_wr && (bus_addr == 3'd3) && go_bit;
    assign rx_rd = bus_rd && (bus_addr == 3'd1);

    p_busy_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && en && !bsy) |=> bsy);

    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bsy |-> (sclk == cidle));

    p_done_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bsy) && en) |-> rbr);

    p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !done) |=> !rbr);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rbr);

    p_off_nostart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !en) |=> !bsy);

    p_off_mosi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mosi);

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .go_bit  (bus_wdata[0]),
    .en      (en_q),
    .cidle   (cidle_q),
    .sclk    (sclk),
    .mosi    (mosi),
    .irq     (irq),
    .bsy     (sh_busy),
    .rbr     (regs_q.rbr),
    .done    (sh_done)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sclk, mosi;
    logic       miso_drv = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // monitor / slave model state
    bit         mon_armed = 0;
    bit         mon_early = 0;
    bit         mon_lsb = 0;
    int         mon_edges = 0;
    logic [7:0] cap = '0;
    logic [7:0] slave = '0;
    logic       last_sclk = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    spi_byte_master u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso_drv)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic sbit(input int j);
        return mon_lsb ? slave[j] : slave[7-j];
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        int guard = 0;
        while (!irq && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // scoreboard monitor: decodes MOSI, plays the slave on MISO
    always @(negedge clk) begin
        if (mon_armed && (sclk !== last_sclk)) begin
            int e;
            int j;
            e = mon_edges + 1;
            mon_edges = e;
            if (mon_early) begin
                if (e % 2 == 1) begin
                    j = (e - 1) / 2;
                    cap[mon_lsb ? j : 7 - j] = mosi;
                end else if (e < 16) begin
                    miso_drv = sbit(e / 2);
                end
            end else begin
                if (e % 2 == 1) begin
                    miso_drv = sbit((e - 1) / 2);
                end else begin
                    j = e / 2 - 1;
                    cap[mon_lsb ? j : 7 - j] = mosi;
                end
            end
            if (e == 16) begin
                mon_armed = 0;
                if (exp_q.size() == 0) begin
                    check("R4 unexpected serial byte", 32'(cap), 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] x;
                    x = exp_q.pop_front();
                    check("R4 R5 MOSI serial byte", 32'(cap), 32'(x));
                end
            end
        end
        last_sclk = sclk;
    end

    task automatic arm(input logic [7:0] md, input logic [7:0] tx, input logic [7:0] sl);
        mon_early = md[4];
        mon_lsb   = md[2];
        slave     = sl;
        mon_edges = 0;
        cap       = '0;
        miso_drv  = sbit(0);
        exp_q.push_back(tx);
        mon_armed = 1;
    endtask

    task automatic run_xfer(input logic [7:0] md, input logic [7:0] dv,
                            input logic [7:0] tx, input logic [7:0] sl, input string tag);
        logic [7:0] d;
        time t0;
        int cyc;
        bus_write(3'd6, dv);
        bus_write(3'd0, md);
        bus_write(3'd2, tx);
        check({tag, " R4 idle sclk"}, 32'(sclk), 32'(md[1]));
        arm(md, tx, sl);
        bus_write(3'd3, 8'h01);
        t0 = $time;
        wait_irq();
        cyc = int'(($time - t0) / CLK_NS);
        check({tag, " R11 cycles to done"}, 32'(cyc), 32'(32 * (int'(dv) + 1)));
        check({tag, " R7 irq high"}, 32'(irq), 32'h1);
        bus_read(3'd4, d);
        check({tag, " R6 status done"}, 32'(d), 32'h01);
        bus_read(3'd1, d);
        check({tag, " R6 R5 rx byte"}, 32'(d), md[0] ? 32'(tx) : 32'(sl));
        bus_read(3'd4, d);
        check({tag, " R7 status cleared"}, 32'(d), 32'h00);
        check({tag, " R7 irq low"}, 32'(irq), 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        time t0;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(3'd0, d); check("R1 mode reset", 32'(d), 0);
        bus_read(3'd4, d); check("R1 status reset", 32'(d), 0);
        bus_read(3'd6, d); check("R1 div reset", 32'(d), 0);
        check("R1 sclk reset", 32'(sclk), 0);
        check("R1 mosi reset", 32'(mosi), 0);
        check("R1 irq reset", 32'(irq), 0);

        // R2 readback
        bus_write(3'd0, 8'hFF); bus_read(3'd0, d); check("R2 mode readback", 32'(d), 32'h1F);
        bus_write(3'd6, 8'hA5); bus_read(3'd6, d); check("R2 div readback", 32'(d), 32'hA5);
        bus_write(3'd2, 8'h3C); bus_read(3'd2, d); check("R2 txd readback", 32'(d), 32'h3C);
        bus_read(3'd3, d); check("R2 ctrl reads zero", 32'(d), 0);
        bus_read(3'd5, d); check("R2 offset5 zero", 32'(d), 0);
        bus_read(3'd7, d); check("R2 offset7 zero", 32'(d), 0);

        // R9 disabled: start ignored, idle level, MOSI low
        bus_write(3'd0, 8'h02);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd3, 8'h01);
        bus_read(3'd4, d); check("R9 start ignored when off", 32'(d), 0);
        check("R9 sclk idle high when off", 32'(sclk), 1);
        check("R9 mosi low when off", 32'(mosi), 0);

        // transfers in each mode
        run_xfer(8'h18, 8'd0,   8'hA5, 8'h3C, "mode0 msb");
        run_xfer(8'h08, 8'd2,   8'h96, 8'hC3, "mode1 msb");
        run_xfer(8'h1A, 8'd1,   8'h0F, 8'hF0, "mode2 msb");
        run_xfer(8'h0E, 8'd0,   8'h01, 8'h80, "mode3 lsb");
        run_xfer(8'h1C, 8'd255, 8'h6B, 8'hD2, "mode0 lsb div255");
        run_xfer(8'h19, 8'd0,   8'h5E, 8'hFF, "R10 loopback");

        // R7 irq gated by enable
        bus_write(3'd6, 8'd0);
        bus_write(3'd0, 8'h18);
        bus_write(3'd2, 8'h42);
        arm(8'h18, 8'h42, 8'h24);
        bus_write(3'd3, 8'h01);
        wait_irq();
        bus_write(3'd0, 8'h10);
        check("R7 irq low when disabled", 32'(irq), 0);
        bus_write(3'd0, 8'h18);
        check("R7 irq back with enable", 32'(irq), 1);
        bus_read(3'd1, d); check("R6 rx after gating", 32'(d), 32'h24);
        check("R7 irq low after read", 32'(irq), 0);

        // R8 start while busy ignored
        bus_write(3'd6, 8'd1);
        bus_write(3'd2, 8'h81);
        arm(8'h18, 8'h81, 8'h7E);
        bus_write(3'd3, 8'h01);
        t0 = $time;
        bus_read(3'd4, d); check("R3 busy after start", 32'(d), 32'h02);
        repeat (10) @(negedge clk);
        bus_write(3'd2, 8'h00);
        bus_write(3'd3, 8'h01);
        wait_irq();
        cyc = int'(($time - t0) / CLK_NS);
        check("R8 length unchanged by second start", 32'(cyc), 32'd64);
        bus_read(3'd4, d); check("R8 status after ignored start", 32'(d), 32'h01);
        bus_read(3'd1, d); check("R8 rx byte", 32'(d), 32'h7E);
        bus_read(3'd2, d); check("R2 txd rewritten", 32'(d), 32'h00);
        bus_read(3'd4, d); check("R8 no second transfer", 32'(d), 32'h00);

        // R9 abort mid transfer
        bus_write(3'd6, 8'd3);
        bus_write(3'd2, 8'hFF);
        bus_write(3'd3, 8'h01);
        repeat (20) @(negedge clk);
        bus_write(3'd0, 8'h10);
        check("R9 mosi low after abort", 32'(mosi), 0);
        check("R9 sclk idle after abort", 32'(sclk), 0);
        bus_read(3'd4, d); check("R9 abort status", 32'(d), 0);
        repeat (300) @(negedge clk);
        bus_read(3'd4, d); check("R9 no flag after abort", 32'(d), 0);
        check("R9 irq low after abort", 32'(irq), 0);
        check("R4 scoreboard drained", 32'(exp_q.size()), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule